// File: doc/BRIEF.md
# Packed Signed Saturating Adder

This unit adds two 32-bit operands as packed vectors of small signed integers. A run-time mode input decides how each operand is split: either into four signed bytes or into two signed halfwords. Each lane pair is added on its own, and no carry crosses a lane edge. Each lane sum is then clamped to the signed range of that lane's width, and the clamped value goes back to the bit position its lane came from.

Every lane also raises a saturation flag when its clamp was applied. The adder logic itself is combinational. A parameter puts one register stage behind it, and a valid bit travels with the data so that a downstream consumer knows when a new result is present. The block fits in a datapath that handles audio samples or pixel channels, where a wrap-around would be far worse than a clipped value.

Top module: `lane_sat_adder`

## Requirements
- R1: With `lane_mode` = 0 (byte mode), bits [8i+7:8i] of `result` hold the signed sum of the matching byte lanes of `op_a` and `op_b` for i = 0..3, and no carry passes from one byte lane to the next.
- R2: In byte mode a lane sum above 127 is replaced by 8'h7F, and a lane sum below -128 is replaced by 8'h80.
- R3: With `lane_mode` = 1 (halfword mode), `result[15:0]` and `result[31:16]` hold the signed sums of the low and high halfwords, and no carry passes between the two halves.
- R4: In halfword mode a lane sum above 32767 is replaced by 16'h7FFF, and a lane sum below -32768 is replaced by 16'h8000.
- R5: A lane saturates only when both of its operands have the same sign and the wrapped sum has the opposite sign. Operands of opposite sign never saturate.
- R6: In byte mode `sat_flags[i]` is set exactly when byte lane i was clamped. In halfword mode `sat_flags[0]` marks the low halfword and `sat_flags[2]` marks the high halfword, while `sat_flags[1]` and `sat_flags[3]` read 0.
- R7: With the output register enabled (the default), `result` and `sat_flags` reflect an input one clock after `in_valid` is sampled high, and `out_valid` equals the value `in_valid` had one clock earlier.
- R8: On a clock where `in_valid` is low, `result` and `sat_flags` keep their previous values.
- R9: While the synchronous active-high `rst` is asserted, `out_valid`, `result` and `sat_flags` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| lane_mode | input | 1 | 0 = four byte lanes, 1 = two halfword lanes |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand |
| out_valid | output | 1 | A new result is present |
| result | output | 32 | Packed, saturated lane sums |
| sat_flags | output | 4 | Per-lane saturation indicators |

## Verification
Two behaviours can fall in one cycle: a lane clamp can happen in one lane while a neighbouring lane sees a pattern that would carry into it if lanes were not isolated. Vectors such as 0x7FFF_FF80 + 0x0001_0080 provoke this by overflowing one lane while the lane beside it produces a carry-out. The bench judges each lane on its own against a sum computed as a wide integer and then clamped. A mode switch between back-to-back valid cycles is also applied, so that byte and halfword results follow each other directly.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
  typedef enum logic {
    LM_BYTE = 1'b0,
    LM_HALF = 1'b1
  } lane_mode_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;
endpackage

// File: rtl/sat_lane_add.sv
module sat_lane_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         sat
);
  logic [W-1:0] raw;
  logic         pos_ovf;
  logic         neg_ovf;

  always_comb begin
    raw     = a + b;
    pos_ovf = !a[W-1] && !b[W-1] &&  raw[W-1];
    neg_ovf =  a[W-1] &&  b[W-1] && !raw[W-1];
    if (pos_ovf)      sum = {1'b0, {(W-1){1'b1}}};
    else if (neg_ovf) sum = {1'b1, {(W-1){1'b0}}};
    else              sum = raw;
    sat = pos_ovf || neg_ovf;
  end
endmodule

// File: rtl/packed_sat_core.sv
module packed_sat_core
  import simd_sat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  lane_mode_e                      mode,
  input  logic [DATA_W-1:0]               a,
  input  logic [DATA_W-1:0]               b,
  output logic [DATA_W-1:0]               res,
  output logic [DATA_W/BYTE_W-1:0]        flags
);
  localparam int unsigned NB = DATA_W / BYTE_W;
  localparam int unsigned NH = DATA_W / HALF_W;
  localparam int unsigned STRIDE = HALF_W / BYTE_W;

  logic [DATA_W-1:0] res_b, res_h;
  logic [NB-1:0]     flg_b, flg_h;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    sat_lane_add #(.W(BYTE_W)) u_lane (
      .a  (a[i*BYTE_W +: BYTE_W]),
      .b  (b[i*BYTE_W +: BYTE_W]),
      .sum(res_b[i*BYTE_W +: BYTE_W]),
      .sat(flg_b[i])
    );
  end

  for (genvar j = 0; j < NH; j++) begin : g_half
    sat_lane_add #(.W(HALF_W)) u_lane (
      .a  (a[j*HALF_W +: HALF_W]),
      .b  (b[j*HALF_W +: HALF_W]),
      .sum(res_h[j*HALF_W +: HALF_W]),
      .sat(flg_h[j*STRIDE])
    );
    for (genvar k = 1; k < STRIDE; k++) begin : g_zero
      assign flg_h[j*STRIDE + k] = 1'b0;
    end
  end

  always_comb begin
    if (mode == LM_HALF) begin
      res   = res_h;
      flags = flg_h;
    end else begin
      res   = res_b;
      flags = flg_b;
    end
  end
endmodule

// File: rtl/lane_sat_adder.sv
module lane_sat_adder
  import simd_sat_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     lane_mode,
  input  logic [DATA_W-1:0]        op_a,
  input  logic [DATA_W-1:0]        op_b,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        result,
  output logic [DATA_W/BYTE_W-1:0] sat_flags
);
  localparam int unsigned NB = DATA_W / BYTE_W;
  localparam int unsigned NH = DATA_W / HALF_W;

  logic [DATA_W-1:0] comb_res;
  logic [NB-1:0]     comb_flg;

  packed_sat_core #(.DATA_W(DATA_W)) u_core (
    .mode (lane_mode_e'(lane_mode)),
    .a    (op_a),
    .b    (op_b),
    .res  (comb_res),
    .flags(comb_flg)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        result    <= '0;
        sat_flags <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          result    <= comb_res;
          sat_flags <= comb_flg;
        end
      end
    end

    assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    assert_valid_drop_R7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(result) && $stable(sat_flags)));
    assert_half_flags_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lane_mode) |=> (sat_flags[1] == 1'b0 && sat_flags[3] == 1'b0));

    for (genvar i = 0; i < NB; i++) begin : g_chk_b
      assert_byte_clamp_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !lane_mode) |=> (!sat_flags[i] ||
          result[i*BYTE_W +: BYTE_W] == 8'h7F || result[i*BYTE_W +: BYTE_W] == 8'h80));
      assert_no_sat_mixed_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !lane_mode && (op_a[i*BYTE_W+7] != op_b[i*BYTE_W+7]))
          |=> !sat_flags[i]);
    end
    for (genvar j = 0; j < NH; j++) begin : g_chk_h
      assert_half_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_mode) |=> (!sat_flags[2*j] ||
          result[j*HALF_W +: HALF_W] == 16'h7FFF || result[j*HALF_W +: HALF_W] == 16'h8000));
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = comb_res;
    assign sat_flags = comb_flg;
  end
endmodule

// File: tb/lane_sat_adder_tb_top.sv
module lane_sat_adder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        lane_mode = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  sat_flags;

  int checks = 0;
  int fails  = 0;

  logic        exp_valid = 1'b0;
  logic [31:0] exp_res   = '0;
  logic [3:0]  exp_flg   = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_sat_adder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_mode(lane_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .result(result), .sat_flags(sat_flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Wide-precision reference for one lane
  function automatic void ref_lane(input int w, input logic [15:0] x, input logic [15:0] y,
                                   output logic [15:0] s, output logic f);
    int xa, yb, sum, hi, lo;
    xa = (w == 8) ? int'($signed(x[7:0])) : int'($signed(x));
    yb = (w == 8) ? int'($signed(y[7:0])) : int'($signed(y));
    sum = xa + yb;
    hi = (w == 8) ? 127 : 32767;
    lo = (w == 8) ? -128 : -32768;
    f = 1'b0;
    if (sum > hi) begin sum = hi; f = 1'b1; end
    if (sum < lo) begin sum = lo; f = 1'b1; end
    s = 16'(sum);
  endfunction

  task automatic step(input logic v, input logic m, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    logic [15:0] s;
    logic f;
    in_valid = v; lane_mode = m; op_a = a; op_b = b;
    @(posedge clk);
    @(negedge clk);
    exp_valid = v;
    if (v) begin
      exp_flg = '0;
      if (!m) begin
        for (int i = 0; i < 4; i++) begin
          ref_lane(8, {8'h0, a[i*8 +: 8]}, {8'h0, b[i*8 +: 8]}, s, f);
          exp_res[i*8 +: 8] = s[7:0];
          exp_flg[i] = f;
        end
      end else begin
        for (int j = 0; j < 2; j++) begin
          ref_lane(16, a[j*16 +: 16], b[j*16 +: 16], s, f);
          exp_res[j*16 +: 16] = s;
          exp_flg[2*j] = f;
        end
      end
    end
    chk({tag, " R7 out_valid"}, {31'b0, out_valid}, {31'b0, exp_valid});
    chk({tag, " result"}, result, exp_res);
    chk({tag, " R6 sat_flags"}, {28'b0, sat_flags}, {28'b0, exp_flg});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset valid", {31'b0, out_valid}, 32'b0);
    chk("R9 reset result", result, 32'b0);
    chk("R9 reset flags", {28'b0, sat_flags}, 32'b0);
    rst = 1'b0;

    step(1, 0, 32'h0102_0304, 32'h1010_1010, "R1 plain bytes");
    step(1, 0, 32'h00FF_00FF, 32'h0001_0001, "R1 no carry across bytes");
    step(1, 0, 32'h7F80_7F80, 32'h01FF_7F80, "R2 byte clamps");
    step(1, 0, 32'h7F80_4080, 32'h807F_C07F, "R5 mixed signs no sat");
    step(1, 0, 32'h7FFF_FF80, 32'h0001_0080, "R2 clamp beside carry");
    step(1, 1, 32'h1234_00FF, 32'h0001_0001, "R3 plain halves");
    step(1, 1, 32'h0000_FFFF, 32'h0000_0001, "R3 no carry across halves");
    step(1, 1, 32'h7FFF_8000, 32'h0001_8000, "R4 half clamps");
    step(1, 1, 32'h8000_7FFF, 32'h8000_7FFF, "R4 both halves clamp");
    step(1, 1, 32'h7FFF_8000, 32'h8000_7FFF, "R5 half mixed signs");
    step(1, 0, 32'h7FFF_8000, 32'h0101_8080, "R1 mode switch back");
    step(0, 1, 32'h7F7F_7F7F, 32'h7F7F_7F7F, "R8 hold");
    step(0, 0, 32'h8080_8080, 32'h8080_8080, "R8 hold again");
    for (int n = 0; n < 200; n++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           $urandom, $urandom, "R1 R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule